// File: doc/BRIEF.md
# Codelet Firing Scheduler

This block lives inside one processing element of a dataflow compute array. Rather than fetching along a program counter, it runs work as codelets: each codelet is a contiguous run of instructions held in a local instruction store, plus a descriptor. The descriptor gives the first instruction address, the instruction count, the number of input tokens the codelet needs, and a mask of the execution resources it uses. During an initialization phase a preload port fills the instruction store and the descriptor table. While that phase is active the scheduler starts no codelet, so the compute pipeline stays idle.

Token-arrival pulses, one line per codelet, feed per-codelet counters. A codelet becomes eligible when two conditions hold: its counter has reached the required count, and every resource in its mask is reported free. A rotating arbiter picks one eligible codelet. When it is launched, the required tokens are taken from its counter. The sequencer then streams the codelet's instructions in address order over a valid/ready interface, with each beat tagged by the codelet index. A one-cycle done pulse marks the end of the codelet.

Top module: `codelet_fire_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `iss_valid` and `done_pulse` are low.
- R2: A preload write stores `ld_instr_data` at `ld_instr_addr`, and a descriptor write stores the start, length, need and resource mask of codelet `ld_desc_idx`. Issued beats return exactly the preloaded words.
- R3: A codelet does not launch while its received-token count is below its need value. It launches once the count has reached the need value.
- R4: A codelet does not launch while any bit set in its resource mask is clear in `res_free`. It launches once all of those bits are set (bit i of the mask means resource i).
- R5: While `init_mode` is high, no new codelet launches. Eligibility is kept, and launching resumes when `init_mode` falls.
- R6: A launched codelet issues exactly `len` beats on `iss_data`, read from addresses start, start+1, and so on in increasing order. Every beat carries the codelet's index on `iss_cl`.
- R7: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_data` and `iss_cl` hold their values.
- R8: In the cycle after the last beat's handshake, `done_pulse` is high for exactly one cycle, with `done_cl` equal to the finished codelet's index.
- R9: When several codelets are eligible, the winner is the first eligible index found searching upward, with wrap-around, from the index after the last codelet launched. After reset the search starts at index 0.
- R10: Launching subtracts the need value from the counter. Token pulses that arrive while the codelet is issuing are kept and can launch it again right away. No extra firing happens without tokens.
- R11: A codelet whose descriptor length is zero, and every codelet never written since reset, never launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mode | input | 1 | Initialization phase; blocks new launches |
| ld_instr_we | input | 1 | Instruction store write enable |
| ld_instr_addr | input | ADDR_W | Instruction store write address |
| ld_instr_data | input | INSTR_W | Instruction word to store |
| ld_desc_we | input | 1 | Descriptor write enable |
| ld_desc_idx | input | IDX_W | Codelet whose descriptor is written |
| ld_desc_start | input | ADDR_W | First instruction address |
| ld_desc_len | input | LEN_W | Instruction count (0 disables) |
| ld_desc_need | input | TOK_W | Tokens required per firing |
| ld_desc_rmask | input | NUM_RES | Resources required |
| tok_pulse | input | NUM_CL | One token per set bit per cycle, bit i for codelet i |
| res_free | input | NUM_RES | Resources currently free |
| iss_valid | output | 1 | Instruction beat valid |
| iss_ready | input | 1 | Pipeline accepts the beat |
| iss_data | output | INSTR_W | Instruction word |
| iss_cl | output | IDX_W | Index of the issuing codelet |
| done_pulse | output | 1 | One-cycle end-of-codelet pulse |
| done_cl | output | IDX_W | Index of the finished codelet |

## Verification
Single codelets are driven first with fewer tokens than needed and then with enough. This separates a count comparison from a launch on the first token. A missing resource bit is then supplied late, which shows that the mask gates launch independently of tokens. Several codelets are made eligible together while `init_mode` is high, and two such groups are chosen so that plain lowest-index priority would give a different order than rotation from the last launch. Tokens are injected while a codelet is stalled mid-issue, and the bench checks for exactly one refire. This separates keeping the carried tokens from clearing the counter and from firing repeatedly.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_ISSUE = 1'b1
   } seq_state_t;
endpackage

// File: rtl/cfs_instr_store.sv
module cfs_instr_store #(
   parameter int DEPTH  = 64,
   parameter int WIDTH  = 32,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cfs_desc_table.sv
module cfs_desc_table #(
   parameter int N      = 16,
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 6,
   parameter int LEN_W  = 7,
   parameter int TOK_W  = 4,
   parameter int RES_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           idx,
   input  logic [ADDR_W-1:0]          w_start,
   input  logic [LEN_W-1:0]           w_len,
   input  logic [TOK_W-1:0]           w_need,
   input  logic [RES_W-1:0]           w_rmask,
   output logic [N-1:0][ADDR_W-1:0]   d_start,
   output logic [N-1:0][LEN_W-1:0]    d_len,
   output logic [N-1:0][TOK_W-1:0]    d_need,
   output logic [N-1:0][RES_W-1:0]    d_rmask,
   output logic [N-1:0]               d_live
);
   for (genvar i = 0; i < N; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            d_start[i] <= '0;
            d_len[i]   <= '0;
            d_need[i]  <= '0;
            d_rmask[i] <= '0;
         end else if (we && idx == IDX_W'(i)) begin
            d_start[i] <= w_start;
            d_len[i]   <= w_len;
            d_need[i]  <= w_need;
            d_rmask[i] <= w_rmask;
         end
      end
      assign d_live[i] = (d_len[i] != '0);
   end
endmodule

// File: rtl/cfs_token_bank.sv
module cfs_token_bank #(
   parameter int N     = 16,
   parameter int IDX_W = 4,
   parameter int TOK_W = 4,
   parameter int RES_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N-1:0]             tok_in,
   input  logic [N-1:0][TOK_W-1:0]  need,
   input  logic [N-1:0][RES_W-1:0]  rmask,
   input  logic [N-1:0]             live,
   input  logic [RES_W-1:0]         res_free,
   input  logic                     launch,
   input  logic [IDX_W-1:0]         launch_idx,
   output logic [N-1:0]             ready
);
   localparam logic [TOK_W-1:0] CNT_MAX = '1;

   for (genvar i = 0; i < N; i++) begin : g_cnt
      logic [TOK_W-1:0] cnt;
      logic [TOK_W-1:0] base;
      logic [TOK_W-1:0] nxt;
      logic             consume;

      always_comb begin
         consume = launch && (launch_idx == IDX_W'(i));
         base    = consume ? (cnt - need[i]) : cnt;
         nxt     = (tok_in[i] && base != CNT_MAX) ? base + 1'b1 : base;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= nxt;
      end

      assign ready[i] = live[i] && (cnt >= need[i]) &&
                        ((rmask[i] & ~res_free) == '0);

      // R3: a launch never takes more tokens than the counter holds
      p_launch_tokens_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (launch && launch_idx == IDX_W'(i)) |-> (cnt >= need[i]));
   end
endmodule

// File: rtl/cfs_rr_arbiter.sv
module cfs_rr_arbiter #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] last,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);
   always_comb begin
      int c;
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int k = 1; k <= N; k++) begin
         c = int'(last) + k;
         if (c >= N) c = c - N;
         if (!gnt_valid && req[c]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(c);
         end
      end
   end
endmodule

// File: rtl/codelet_fire_sched.sv
module codelet_fire_sched
   import cfs_pkg::*;
#(
   parameter int NUM_CL     = 16,
   parameter int IMEM_DEPTH = 64,
   parameter int INSTR_W    = 32,
   parameter int NUM_RES    = 4,
   parameter int TOK_W      = 4,
   localparam int IDX_W     = $clog2(NUM_CL),
   localparam int ADDR_W    = $clog2(IMEM_DEPTH),
   localparam int LEN_W     = $clog2(IMEM_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_mode,
   input  logic               ld_instr_we,
   input  logic [ADDR_W-1:0]  ld_instr_addr,
   input  logic [INSTR_W-1:0] ld_instr_data,
   input  logic               ld_desc_we,
   input  logic [IDX_W-1:0]   ld_desc_idx,
   input  logic [ADDR_W-1:0]  ld_desc_start,
   input  logic [LEN_W-1:0]   ld_desc_len,
   input  logic [TOK_W-1:0]   ld_desc_need,
   input  logic [NUM_RES-1:0] ld_desc_rmask,
   input  logic [NUM_CL-1:0]  tok_pulse,
   input  logic [NUM_RES-1:0] res_free,
   output logic               iss_valid,
   input  logic               iss_ready,
   output logic [INSTR_W-1:0] iss_data,
   output logic [IDX_W-1:0]   iss_cl,
   output logic               done_pulse,
   output logic [IDX_W-1:0]   done_cl
);
   if (NUM_CL < 2 || NUM_CL > 64) begin : g_bad_ncl
      $error("NUM_CL must lie in 2..64");
   end
   if (IMEM_DEPTH < 2 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("IMEM_DEPTH must be a power of two of at least 2");
   end
   if (TOK_W < 1 || NUM_RES < 1 || INSTR_W < 1) begin : g_bad_w
      $error("TOK_W, NUM_RES and INSTR_W must be positive");
   end

   logic [NUM_CL-1:0][ADDR_W-1:0]  d_start;
   logic [NUM_CL-1:0][LEN_W-1:0]   d_len;
   logic [NUM_CL-1:0][TOK_W-1:0]   d_need;
   logic [NUM_CL-1:0][NUM_RES-1:0] d_rmask;
   logic [NUM_CL-1:0]              d_live;
   logic [NUM_CL-1:0]              cl_ready;
   logic                           gnt_valid;
   logic [IDX_W-1:0]               gnt_idx;
   logic                           launch;

   seq_state_t       state;
   logic [IDX_W-1:0] cur_cl;
   logic [IDX_W-1:0] last_cl;
   logic [ADDR_W-1:0] ptr;
   logic [LEN_W-1:0]  rem;
   logic              last_beat;

   cfs_instr_store #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (ld_instr_we),
      .waddr (ld_instr_addr),
      .wdata (ld_instr_data),
      .raddr (ptr),
      .rdata (iss_data)
   );

   cfs_desc_table #(.N(NUM_CL), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                    .TOK_W(TOK_W), .RES_W(NUM_RES)) u_desc (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ld_desc_we),
      .idx     (ld_desc_idx),
      .w_start (ld_desc_start),
      .w_len   (ld_desc_len),
      .w_need  (ld_desc_need),
      .w_rmask (ld_desc_rmask),
      .d_start (d_start),
      .d_len   (d_len),
      .d_need  (d_need),
      .d_rmask (d_rmask),
      .d_live  (d_live)
   );

   cfs_token_bank #(.N(NUM_CL), .IDX_W(IDX_W), .TOK_W(TOK_W), .RES_W(NUM_RES)) u_tok (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_in     (tok_pulse),
      .need       (d_need),
      .rmask      (d_rmask),
      .live       (d_live),
      .res_free   (res_free),
      .launch     (launch),
      .launch_idx (gnt_idx),
      .ready      (cl_ready)
   );

   cfs_rr_arbiter #(.N(NUM_CL), .IDX_W(IDX_W)) u_arb (
      .req       (cl_ready),
      .last      (last_cl),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   assign launch    = (state == SEQ_IDLE) && !init_mode && gnt_valid;
   assign last_beat = (state == SEQ_ISSUE) && iss_ready && (rem == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         cur_cl     <= '0;
         last_cl    <= IDX_W'(NUM_CL - 1);
         ptr        <= '0;
         rem        <= '0;
         done_pulse <= 1'b0;
         done_cl    <= '0;
      end else begin
         done_pulse <= last_beat;
         if (last_beat) done_cl <= cur_cl;
         case (state)
            SEQ_IDLE: if (launch) begin
               state   <= SEQ_ISSUE;
               cur_cl  <= gnt_idx;
               last_cl <= gnt_idx;
               ptr     <= d_start[gnt_idx];
               rem     <= d_len[gnt_idx];
            end
            SEQ_ISSUE: if (iss_ready) begin
               ptr <= ptr + 1'b1;
               rem <= rem - 1'b1;
               if (rem == LEN_W'(1)) state <= SEQ_IDLE;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign iss_valid = (state == SEQ_ISSUE);
   assign iss_cl    = cur_cl;

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready && !ld_instr_we) |=>
         (iss_valid && $stable(iss_data) && $stable(iss_cl)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   p_no_launch_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (init_mode && !iss_valid) |=> !iss_valid);

   p_launch_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> ((d_rmask[gnt_idx] & ~res_free) == '0));

   p_grant_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> cl_ready[gnt_idx]);

   p_zero_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (d_len[gnt_idx] != '0));
endmodule

// File: tb/codelet_fire_sched_test.sv
`timescale 1ns/1ps
module codelet_fire_sched_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_mode = 1'b1;
   logic        ld_instr_we = 1'b0;
   logic [5:0]  ld_instr_addr = '0;
   logic [31:0] ld_instr_data = '0;
   logic        ld_desc_we = 1'b0;
   logic [3:0]  ld_desc_idx = '0;
   logic [5:0]  ld_desc_start = '0;
   logic [6:0]  ld_desc_len = '0;
   logic [3:0]  ld_desc_need = '0;
   logic [3:0]  ld_desc_rmask = '0;
   logic [15:0] tok_pulse = '0;
   logic [3:0]  res_free = 4'hF;
   logic        iss_ready = 1'b1;
   logic        iss_valid;
   logic [31:0] iss_data;
   logic [3:0]  iss_cl;
   logic        done_pulse;
   logic [3:0]  done_cl;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   codelet_fire_sched uut (
      .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
      .ld_instr_we(ld_instr_we), .ld_instr_addr(ld_instr_addr), .ld_instr_data(ld_instr_data),
      .ld_desc_we(ld_desc_we), .ld_desc_idx(ld_desc_idx), .ld_desc_start(ld_desc_start),
      .ld_desc_len(ld_desc_len), .ld_desc_need(ld_desc_need), .ld_desc_rmask(ld_desc_rmask),
      .tok_pulse(tok_pulse), .res_free(res_free),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_data(iss_data), .iss_cl(iss_cl),
      .done_pulse(done_pulse), .done_cl(done_cl)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic [15:0] m);
      @(negedge clk) tok_pulse = m;
      @(negedge clk) tok_pulse = '0;
   endtask

   task automatic quiet(input int cycles, input string tag);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk(!iss_valid, tag, {31'b0, iss_valid}, 32'h0);
      end
   endtask

   // expects one whole codelet with iss_ready held high
   task automatic collect(input int cl, input int start, input int len, input string tag);
      int w = 0;
      while (!iss_valid && w < 40) begin @(negedge clk); w++; end
      for (int k = 0; k < len; k++) begin
         chk(iss_valid && iss_data == 32'hC0DE_0000 + 32'(start + k) && iss_cl == 4'(cl),
             {tag, " R6 beat"}, iss_data, 32'hC0DE_0000 + 32'(start + k));
         @(negedge clk);
      end
      chk(done_pulse && done_cl == 4'(cl), {tag, " R8 done"}, {27'b0, done_pulse, done_cl}, {27'b1, 1'b1, 4'(cl)} & 32'h1F);
      @(negedge clk);
      chk(!done_pulse, {tag, " R8 single"}, {31'b0, done_pulse}, 32'h0);
   endtask

   task automatic put_desc(input int idx, input int st, input int len, input int need, input logic [3:0] rm);
      @(negedge clk);
      ld_desc_we = 1'b1; ld_desc_idx = 4'(idx); ld_desc_start = 6'(st);
      ld_desc_len = 7'(len); ld_desc_need = 4'(need); ld_desc_rmask = rm;
      @(negedge clk) ld_desc_we = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(!iss_valid && !done_pulse, "R1 in reset", {30'b0, iss_valid, done_pulse}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!iss_valid && !done_pulse, "R1 after reset", {30'b0, iss_valid, done_pulse}, 32'h0);
   endtask

   task automatic t_preload();
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         ld_instr_we = 1'b1; ld_instr_addr = 6'(a); ld_instr_data = 32'hC0DE_0000 + 32'(a);
      end
      @(negedge clk) ld_instr_we = 1'b0;
      put_desc(0, 0, 3, 2, 4'b0001);
      put_desc(1, 8, 2, 1, 4'b0000);
      put_desc(2, 16, 1, 1, 4'b0010);
      put_desc(3, 24, 0, 1, 4'b0000);
      @(negedge clk) init_mode = 1'b0;
      quiet(3, "R11 unwritten idle");
   endtask

   task automatic t_tokens();
      pulse(16'h0001);
      quiet(5, "R3 below need");
      pulse(16'h0001);
      collect(0, 0, 3, "R3 R2 cl0");
   endtask

   task automatic t_resources();
      @(negedge clk) res_free = 4'b0000;
      pulse(16'h0004);
      quiet(5, "R4 resource missing");
      @(negedge clk) res_free = 4'b0010;
      collect(2, 16, 1, "R4 cl2");
      @(negedge clk) res_free = 4'hF;
   endtask

   task automatic t_rotation();
      @(negedge clk) init_mode = 1'b1;
      pulse(16'h0003);
      pulse(16'h0001);
      quiet(3, "R5 held for R9");
      @(negedge clk) init_mode = 1'b0;
      collect(0, 0, 3, "R9 first after cl2");
      collect(1, 8, 2, "R9 second");
      @(negedge clk) init_mode = 1'b1;
      pulse(16'h0006);
      @(negedge clk) init_mode = 1'b0;
      collect(2, 16, 1, "R9 rotate past cl1");
      collect(1, 8, 2, "R9 wrap to cl1");
   endtask

   task automatic t_stall();
      @(negedge clk) iss_ready = 1'b0;
      pulse(16'h0002);
      @(negedge clk);
      chk(iss_valid && iss_data == 32'hC0DE_0008, "R7 first beat", iss_data, 32'hC0DE_0008);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(iss_valid && iss_data == 32'hC0DE_0008 && iss_cl == 4'd1, "R7 held", iss_data, 32'hC0DE_0008);
      end
      iss_ready = 1'b1;
      collect(1, 8, 2, "R7 resume");
   endtask

   task automatic t_carry();
      @(negedge clk) iss_ready = 1'b0;
      pulse(16'h0002);
      @(negedge clk);
      pulse(16'h0002);
      iss_ready = 1'b1;
      collect(1, 8, 2, "R10 first");
      collect(1, 8, 2, "R10 refire");
      quiet(4, "R10 no extra firing");
   endtask

   task automatic t_init_block();
      @(negedge clk) init_mode = 1'b1;
      pulse(16'h0004);
      quiet(5, "R5 init blocks");
      @(negedge clk) init_mode = 1'b0;
      collect(2, 16, 1, "R5 after init");
   endtask

   task automatic t_zero_len();
      pulse(16'h0008);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!iss_valid && !done_pulse, "R11 zero length", {30'b0, iss_valid, done_pulse}, 32'h0);
      end
   endtask

   initial begin
      t_reset();
      t_preload();
      t_tokens();
      t_resources();
      t_rotation();
      t_stall();
      t_carry();
      t_init_block();
      t_zero_len();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule